// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave that only understands one kind of transaction: a block write. A controller opens the bus with a start condition, sends the device address with the write bit, then a command byte, then a byte count, then the data bytes. The slave acknowledges every byte of a transaction addressed to it, throws the command and count bytes away, and stores the data bytes one after another into a small bank of 8-bit configuration registers, always beginning at register 0. There is no indexed access and no read path.

Both bus lines are sampled on a fast system clock through two-flop synchronizers, and bus events are found by comparing successive synchronized samples. The slave answers only by pulling the data line low through an open-drain enable during acknowledge slots. The register contents are presented on a flat output vector, register 0 in the least significant byte. Registers 6 and 7 exist in the address space but are not implemented: they accept writes and always read zero.

Top module: `cfg_blkwr_slave`

## Requirements
- R1: After reset the registers hold register 0 = 0x06, register 1 = 0xFF, register 2 = 0xFE and every other register 0x00, and the data-line enable is off.
- R2: A start is the data line falling while the clock line is high, a stop is the data line rising while the clock line is high; bits clocked in without a preceding start are not acknowledged.
- R3: A first byte of 0xD2 (address 1101001, write bit 0) is acknowledged by holding the data line low through the ninth clock; any other first byte, including the read form 0xD3, gets no acknowledge and the slave ignores the bus until the next start.
- R4: The second and third bytes of an accepted transaction (command code and byte count) are acknowledged and never change any register, whatever their values.
- R5: Each byte is received most significant bit first; the data bytes that follow the count go into register 0, 1, 2 and so on in order, each acknowledged.
- R6: Data landing on registers 6 and 7 is acknowledged, and those registers stay 0x00.
- R7: Data bytes beyond register 7 are acknowledged and discarded.
- R8: A stop after any complete byte keeps every register written so far; a byte cut short by a stop writes nothing.
- R9: Every start, including a repeated start without a stop, sends the next data byte to register 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| cfg_regs | output | NUM_REGS*8 | Register contents, register 0 in bits 7:0 |

## Verification
The assertions assume the controller changes the data line only while the clock line is low except for deliberate start and stop conditions, that each bus level holds for several system clocks so the synchronizers see every edge, and that the controller never drives the data line low while the slave is acknowledging. The bench drives the lines through tasks that hold each clock phase for six system cycles, move data one cycle after the clock falls, and release the line before every acknowledge slot, so random payloads, lengths and addresses all stay within those assumptions.

// File: rtl/cfg_blkwr_pkg.sv
package cfg_blkwr_pkg;

    localparam int BYTE_W        = 8;
    localparam int BITS_PER_BYTE = 8;
    localparam int LIVE_REGS     = 6;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK
    } link_state_e;

    typedef enum logic [1:0] {
        FLD_ADDR,
        FLD_CMD,
        FLD_CNT,
        FLD_DATA
    } field_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h06;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic reg_writable(input int idx);
        return idx < LIVE_REGS;
    endfunction

    function automatic field_e next_field(input field_e f);
        case (f)
            FLD_ADDR: return FLD_CMD;
            FLD_CMD:  return FLD_CNT;
            default:  return FLD_DATA;
        endcase
    endfunction

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync
    import cfg_blkwr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/cfg_link.sv
module cfg_link
    import cfg_blkwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output logic     sda_oe,
    output wr_req_t  wr,
    output logic     restart,
    output logic     in_ack,
    output logic     busy,
    output logic     data_phase
);
    localparam logic [BYTE_W-1:0] ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam int                CNT_W    = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0]  FULL     = CNT_W'(BITS_PER_BYTE);

    link_state_e       st;
    field_e            fld;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shifted;

    assign shifted = {shreg[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LS_IDLE;
            fld     <= FLD_ADDR;
            bit_cnt <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            wr      <= '0;
            restart <= 1'b0;
        end else begin
            wr.en   <= 1'b0;
            restart <= 1'b0;
            if (ev.start) begin
                st      <= LS_RX;
                fld     <= FLD_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                restart <= 1'b1;
            end else if (ev.stop) begin
                st     <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    LS_RX: begin
                        if (ev.scl_rise && bit_cnt < FULL) begin
                            shreg   <= shifted;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT && fld == FLD_DATA) begin
                                wr.en   <= 1'b1;
                                wr.data <= shifted;
                            end
                        end else if (ev.scl_fall && bit_cnt == FULL) begin
                            if (fld == FLD_ADDR && shreg != ADDR_WR) begin
                                st <= LS_IDLE;
                            end else begin
                                st     <= LS_ACK;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    LS_ACK: begin
                        if (ev.scl_fall) begin
                            st      <= LS_RX;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            fld     <= next_field(fld);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign in_ack     = (st == LS_ACK);
    assign busy       = (st != LS_IDLE);
    assign data_phase = (fld == FLD_DATA);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_blkwr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         restart,
    input  wr_req_t                      wr,
    output logic [IDX_W-1:0]             wr_idx,
    output logic [NUM_REGS*BYTE_W-1:0]   regs
);
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wr_idx <= '0;
        end else if (wr.en && wr_idx < END_IDX) begin
            wr_idx <= wr_idx + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (reg_writable(i)) begin : g_live
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= reg_default(i);
                end else if (wr.en && wr_idx == IDX_W'(i)) begin
                    q <= wr.data;
                end
            end
            assign regs[i*BYTE_W +: BYTE_W] = q;
        end else begin : g_hole
            assign regs[i*BYTE_W +: BYTE_W] = reg_default(i);
        end
    end
endmodule

// File: rtl/cfg_blkwr_slave.sv
module cfg_blkwr_slave
    import cfg_blkwr_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h69
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);

    line_ev_t         ev;
    wr_req_t          wr;
    logic             restart;
    logic             in_ack;
    logic             busy;
    logic             data_phase;
    logic [IDX_W-1:0] wr_idx;

    cfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    cfg_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .sda_oe     (sda_oe),
        .wr         (wr),
        .restart    (restart),
        .in_ack     (in_ack),
        .busy       (busy),
        .data_phase (data_phase)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .wr      (wr),
        .wr_idx  (wr_idx),
        .regs    (cfg_regs)
    );
endmodule

// File: rtl/cfg_blkwr_chk.sv
module cfg_blkwr_chk
    import cfg_blkwr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       sda_oe,
    input logic                       in_ack,
    input logic                       busy,
    input logic                       stop_det,
    input logic                       restart,
    input logic                       wr_en,
    input logic                       data_phase,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        $fell(rst) |-> (cfg_regs[7:0] == 8'h06 && cfg_regs[15:8] == 8'hFF && cfg_regs[23:16] == 8'hFE)); // R1

    AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !busy); // R2

    AST_OE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> in_ack); // R3

    AST_WRITE_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> data_phase); // R4

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (wr_idx == $past(wr_idx) || wr_idx == $past(wr_idx) + IDX_W'(1))); // R5

    AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (rst)
        wr_idx <= IDX_W'(NUM_REGS)); // R7

    AST_RESTART_INDEX: assert property (@(posedge clk) disable iff (rst)
        restart |=> (wr_idx == '0)); // R9

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hole_chk
        if (!reg_writable(i)) begin : g_fixed
            AST_HOLE_FIXED: assert property (@(posedge clk) disable iff (rst)
                cfg_regs[i*BYTE_W +: BYTE_W] == reg_default(i)); // R6
        end
    end
endmodule

bind cfg_blkwr_slave cfg_blkwr_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_oe     (sda_oe),
    .in_ack     (in_ack),
    .busy       (busy),
    .stop_det   (ev.stop),
    .restart    (restart),
    .wr_en      (wr.en),
    .data_phase (data_phase),
    .wr_idx     (wr_idx),
    .cfg_regs   (cfg_regs)
);

// File: tb/cfg_blkwr_slave_bench.sv
module cfg_blkwr_slave_bench;
    localparam int NREG  = 8;
    localparam int PHASE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [7:0] mdl [NREG];
    logic [7:0] pay [40];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfg_blkwr_slave u_cfg_blkwr_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        waitn(1);
        sda_m = b;
        waitn(PHASE - 1);
        scl_m = 1'b1;
        waitn(PHASE);
        scl_m = 1'b0;
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        waitn(1);
        sda_m = 1'b1;
        waitn(PHASE - 1);
        scl_m = 1'b1;
        waitn(PHASE / 2);
        ack = ~sda_line;
        waitn(PHASE - PHASE / 2);
        scl_m = 1'b0;
    endtask

    task automatic do_start();
        waitn(1);
        sda_m = 1'b1;
        waitn(PHASE);
        scl_m = 1'b1;
        waitn(PHASE);
        sda_m = 1'b0;
        waitn(PHASE);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        waitn(1);
        sda_m = 1'b0;
        waitn(PHASE);
        scl_m = 1'b1;
        waitn(PHASE);
        sda_m = 1'b1;
        waitn(PHASE);
    endtask

    // Start, address, command, count, n data bytes from pay[]; model updated
    task automatic run_block(input logic [7:0] abyte, input logic [7:0] cmd,
                             input int n, input bit stop_after);
        logic a;
        bit   hit;
        do_start();
        byte_out(abyte, a);
        hit = (abyte == 8'hD2);
        chk("R3 address ack", 64'(a), 64'(hit));
        if (hit) begin
            byte_out(cmd, a);
            chk("R4 command ack", 64'(a), 64'd1);
            byte_out(8'(n), a);
            chk("R4 count ack", 64'(a), 64'd1);
            for (int i = 0; i < n; i++) begin
                byte_out(pay[i], a);
                chk("R5 data ack", 64'(a), 64'd1);
                if (i < 6) mdl[i] = pay[i];
            end
        end else begin
            byte_out(8'h00, a);
            chk("R3 ignored after bad address", 64'(a), 64'd0);
        end
        if (stop_after) do_stop();
    endtask

    initial begin
        logic a;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        mdl[0] = 8'h06; mdl[1] = 8'hFF; mdl[2] = 8'hFE;
        waitn(4);
        rst = 1'b0;
        waitn(4);

        // R1: reset values
        chk("R1 reset registers", 64'(cfg_regs), 64'h0000_0000_00FE_FF06);
        chk("R1 reset enable", 64'(sda_oe), 64'd0);

        // R5: three bytes
        pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h81;
        run_block(8'hD2, 8'h00, 3, 1);
        chk("R5 sequential fill", 64'(cfg_regs), 64'(model_flat()));

        // R4: command and count alone with odd values
        do_start();
        byte_out(8'hD2, a);
        byte_out(8'h7E, a);
        chk("R4 odd command ack", 64'(a), 64'd1);
        byte_out(8'h20, a);
        do_stop();
        chk("R4 no register change", 64'(cfg_regs), 64'(model_flat()));

        // R3: read form and foreign address
        pay[0] = 8'h11;
        run_block(8'hD3, 8'h00, 1, 1);
        run_block(8'h52, 8'h00, 1, 1);
        chk("R3 regs untouched", 64'(cfg_regs), 64'(model_flat()));

        // R2: bits without start
        waitn(1);
        scl_m = 1'b0;
        byte_out(8'hD2, a);
        chk("R2 no ack without start", 64'(a), 64'd0);
        do_stop();

        // R6 and R7: eleven bytes
        for (int i = 0; i < 11; i++) pay[i] = 8'(8'h90 + i * 3 + 1);
        run_block(8'hD2, 8'h00, 11, 1);
        chk("R6 holes stay zero", 64'(cfg_regs[63:48]), 64'd0);
        chk("R7 excess discarded", 64'(cfg_regs), 64'(model_flat()));

        // R8: partial byte then stop
        pay[0] = 8'h5A; pay[1] = 8'hC3;
        run_block(8'hD2, 8'h00, 2, 0);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        do_stop();
        chk("R8 kept and partial dropped", 64'(cfg_regs), 64'(model_flat()));

        // R9: repeated start
        pay[0] = 8'h12; pay[1] = 8'h34;
        run_block(8'hD2, 8'h00, 2, 0);
        pay[0] = 8'hEE;
        run_block(8'hD2, 8'h00, 1, 1);
        chk("R9 repeated start restarts", 64'(cfg_regs), 64'(model_flat()));

        // random mix
        void'($urandom(32'd1234));
        for (int t = 0; t < 14; t++) begin
            int n;
            logic [7:0] ab;
            n = 1 + int'($urandom % 10);
            ab = (($urandom % 5) == 0) ? 8'($urandom) : 8'hD2;
            for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
            run_block(ab, 8'($urandom), n, 1);
            chk("R5 random block", 64'(cfg_regs), 64'(model_flat()));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule